// File: doc/BRIEF.md
# Lane frame alignment and configuration checker

This block serves one receive lane and sits after the 8b/10b decoder. It takes the decoded octet stream, with a control-character flag and a valid strobe, and first waits through the comma (/K/) characters that precede the alignment sequence. The first octet that is not a comma fixes the frame phase. From that octet on, the block counts octets within a frame and frames within a multiframe, using the programmed octets-per-frame and frames-per-multiframe counts.

The alignment sequence lasts four multiframes. In the second one, the configuration octets that follow the /R/ and /Q/ markers are compared with the locally programmed values. Any difference sets a sticky mismatch flag. After the sequence, the lane is in data mode. There, /F/ and /A/ replacement characters are turned back into data, and their positions are checked. When misplaced characters keep arriving, a frame or multiframe alarm is raised. The block never moves its frame phase. Recovery is left to the host, which drives `init_i` to return the lane to its waiting state.

Top module: `fa_ilas_rx`

## Requirements
- R1: After reset, `valid_o`, `cfg_err_o`, `frame_alarm_o` and `mf_alarm_o` are all low.
- R2: While waiting for lock, /K/ (control flag 1, code 0xBC) produces no output. The first valid octet that is not /K/ comes out one cycle later with `valid_o` and `sof_o` high, as octet 0 of frame 0.
- R3: After lock, `sof_o` is high on every octet whose position within its frame is 0, with a frame length of `frm_octets_i` octets.
- R4: In the second multiframe of the sequence, multiframe octet positions 2, 3, 4 and 5 carry four configuration octets. Position 2 holds the lane ID (zero-extended), position 3 holds octets-per-frame minus 1, position 4 holds frames-per-multiframe minus 1, and position 5 holds `cfg_misc_i`. Any of them that differs from the programmed value sets `cfg_err_o`, which then stays high.
- R5: A sequence whose configuration octets all match leaves `cfg_err_o` low.
- R6: Data mode starts after four multiframes. In data mode, /F/ (control, 0xFC) is output as the last octet of the previous frame, with `ctrl_o` low.
- R7: In data mode, /A/ (control, 0x7C) is output the same way, as the last octet of the previous frame, with `ctrl_o` low.
- R8: In data mode, an /F/ that is not at the last octet of a frame counts as misplaced. A single misplaced /F/ leaves `frame_alarm_o` low. Two successive misplaced /F/ raise it, and it stays high.
- R9: An /F/ at the correct position, arriving between misplaced ones, clears the pending count.
- R10: An /A/ that is not at the last octet of a multiframe counts as misplaced. Two successive misplaced /A/ raise `mf_alarm_o`, and a correct /A/ between them clears the pending count.
- R11: One cycle of `init_i` clears all flags and the output valid strobe, and returns the lane to waiting for lock.
- R12: An alarm does not change the frame phase: `sof_o` keeps its spacing from the original lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Octet clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Return lane to initial state, clear flags |
| valid_i | input | 1 | Input octet valid |
| data_i | input | 8 | Decoded octet |
| ctrl_i | input | 1 | Octet is a control character |
| frm_octets_i | input | $clog2(MAX_F+1) | Octets per frame |
| mf_frames_i | input | $clog2(MAX_K+1) | Frames per multiframe |
| lane_id_i | input | 5 | Programmed lane ID |
| cfg_misc_i | input | 8 | Programmed extra configuration octet |
| valid_o | output | 1 | Output octet valid |
| data_o | output | 8 | Octet with replacement characters restored |
| ctrl_o | output | 1 | Output control flag |
| sof_o | output | 1 | Octet 0 of a frame |
| cfg_err_o | output | 1 | Sticky configuration mismatch |
| frame_alarm_o | output | 1 | Sticky frame alignment alarm |
| mf_alarm_o | output | 1 | Sticky multiframe alignment alarm |

## Verification
Lock is tried with a run of commas followed by a sequence that matches the programmed configuration. It is then tried with sequences that differ only in the lane ID, or only in the multiframe length. This separates correct capture positions from a compare that misses a field. In data mode, each character kind gets three patterns: correctly placed, misplaced once then corrected, and misplaced twice. These tell restoration apart from pass-through, and a clearing pending count from one that only accumulates. After the alarms, the frame-start spacing is checked against the original lock, to show that no correction takes place.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {ST_WAIT, ST_ILAS, ST_DATA} fa_state_e;

  localparam logic [7:0] CH_K = 8'hBC;
  localparam logic [7:0] CH_R = 8'h1C;
  localparam logic [7:0] CH_A = 8'h7C;
  localparam logic [7:0] CH_F = 8'hFC;
  localparam logic [7:0] CH_Q = 8'h9C;

  localparam int CFG_OFS  = 2;  // config follows /R/ and /Q/
  localparam int CFG_N    = 4;
  localparam int ILAS_MFS = 4;
endpackage

// File: rtl/fa_pos_ctr.sv
module fa_pos_ctr #(
  parameter int FW = 5,
  parameter int KW = 6,
  parameter int MW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic [FW-1:0] frm_octets_i,
  input  logic [KW-1:0] mf_frames_i,
  output logic [FW-1:0] oct_o,
  output logic [MW-1:0] mf_oct_o,
  output logic          frm_end_o,
  output logic          mf_end_o
);
  logic [KW-1:0] frm_q;

  assign frm_end_o = (oct_o == frm_octets_i - 1'b1);
  assign mf_end_o  = frm_end_o && (frm_q == mf_frames_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oct_o    <= '0;
      frm_q    <= '0;
      mf_oct_o <= '0;
    end else if (clr_i) begin
      oct_o    <= '0;
      frm_q    <= '0;
      mf_oct_o <= '0;
    end else if (adv_i) begin
      if (frm_end_o) begin
        oct_o <= '0;
        if (mf_end_o) begin
          frm_q    <= '0;
          mf_oct_o <= '0;
        end else begin
          frm_q    <= frm_q + 1'b1;
          mf_oct_o <= mf_oct_o + 1'b1;
        end
      end else begin
        oct_o    <= oct_o + 1'b1;
        mf_oct_o <= mf_oct_o + 1'b1;
      end
    end
  end

  // R3: frame counter wraps at frame end, holds when idle
  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && frm_end_o && !clr_i |=> oct_o == '0);
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !clr_i |=> $stable(oct_o));
endmodule

// File: rtl/fa_cfg_chk.sv
module fa_cfg_chk #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                chk_i,
  input  logic [IW-1:0]       idx_i,
  input  logic [7:0]          octet_i,
  input  logic [N-1:0][7:0]   exp_i,
  output logic                err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            err_o <= 1'b0;
    else if (clr_i)                         err_o <= 1'b0;
    else if (chk_i && octet_i != exp_i[idx_i]) err_o <= 1'b1;
  end

  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !clr_i |=> err_o);
  a_r5_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(chk_i));
endmodule

// File: rtl/fa_align_mon.sv
module fa_align_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic hit_i,
  input  logic ok_i,
  output logic alarm_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      alarm_o <= 1'b0;
    end else if (clr_i) begin
      pend_q  <= 1'b0;
      alarm_o <= 1'b0;
    end else if (hit_i) begin
      if (ok_i) pend_q <= 1'b0;
      else begin
        if (pend_q) alarm_o <= 1'b1;
        pend_q <= 1'b1;
      end
    end
  end

  // R8/R10: alarm only after a misplaced hit, then sticky
  a_r8_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> $past(hit_i && !ok_i));
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o && !clr_i |=> alarm_o);
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && ok_i && !clr_i && !alarm_o |=> !alarm_o);
endmodule

// File: rtl/fa_ilas_rx.sv
module fa_ilas_rx
  import fa_pkg::*;
#(
  parameter int MAX_F = 16,
  parameter int MAX_K = 32,
  parameter int LID_W = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       init_i,
  input  logic                       valid_i,
  input  logic [7:0]                 data_i,
  input  logic                       ctrl_i,
  input  logic [$clog2(MAX_F+1)-1:0] frm_octets_i,
  input  logic [$clog2(MAX_K+1)-1:0] mf_frames_i,
  input  logic [LID_W-1:0]           lane_id_i,
  input  logic [7:0]                 cfg_misc_i,
  output logic                       valid_o,
  output logic [7:0]                 data_o,
  output logic                       ctrl_o,
  output logic                       sof_o,
  output logic                       cfg_err_o,
  output logic                       frame_alarm_o,
  output logic                       mf_alarm_o
);
  localparam int FW = $clog2(MAX_F+1);
  localparam int KW = $clog2(MAX_K+1);
  localparam int MW = $clog2(MAX_F*MAX_K);
  localparam int IW = $clog2(CFG_N);
  localparam int MI = $clog2(ILAS_MFS);
  localparam logic [MW-1:0] CFG_LO  = MW'(CFG_OFS);
  localparam logic [MW-1:0] CFG_HI  = MW'(CFG_OFS + CFG_N);
  localparam logic [MI-1:0] LAST_MF = MI'(ILAS_MFS - 1);
  localparam logic [MI-1:0] CFG_MF  = MI'(1);

  fa_state_e     st_q;
  logic [MI-1:0] mf_idx_q;
  logic [7:0]    last_q;
  logic [FW-1:0] oct;
  logic [MW-1:0] mf_oct;
  logic          frm_end, mf_end;
  logic          is_k, is_f, is_a, adv, in_data, repl, cfg_chk;
  logic [7:0]    out_d;
  logic [CFG_N-1:0][7:0] cfg_exp;

  assign is_k    = ctrl_i && data_i == CH_K;
  assign is_f    = ctrl_i && data_i == CH_F;
  assign is_a    = ctrl_i && data_i == CH_A;
  assign adv     = valid_i && !init_i && (st_q != ST_WAIT || !is_k);
  assign in_data = adv && st_q == ST_DATA;
  assign repl    = in_data && (is_f || is_a);
  assign out_d   = repl ? last_q : data_i;
  assign cfg_chk = adv && st_q != ST_DATA && mf_idx_q == CFG_MF
                   && mf_oct >= CFG_LO && mf_oct < CFG_HI;

  assign cfg_exp[0] = 8'(lane_id_i);
  assign cfg_exp[1] = 8'(frm_octets_i - 1'b1);
  assign cfg_exp[2] = 8'(mf_frames_i - 1'b1);
  assign cfg_exp[3] = cfg_misc_i;

  fa_pos_ctr #(.FW(FW), .KW(KW), .MW(MW)) u_pos (
    .clk_i, .rst_ni, .clr_i(init_i), .adv_i(adv),
    .frm_octets_i, .mf_frames_i,
    .oct_o(oct), .mf_oct_o(mf_oct), .frm_end_o(frm_end), .mf_end_o(mf_end)
  );

  fa_cfg_chk #(.N(CFG_N), .IW(IW)) u_cfg (
    .clk_i, .rst_ni, .clr_i(init_i), .chk_i(cfg_chk),
    .idx_i(IW'(mf_oct - CFG_LO)), .octet_i(data_i), .exp_i(cfg_exp),
    .err_o(cfg_err_o)
  );

  fa_align_mon u_fmon (
    .clk_i, .rst_ni, .clr_i(init_i),
    .hit_i(in_data && is_f), .ok_i(frm_end), .alarm_o(frame_alarm_o)
  );

  fa_align_mon u_amon (
    .clk_i, .rst_ni, .clr_i(init_i),
    .hit_i(in_data && is_a), .ok_i(mf_end), .alarm_o(mf_alarm_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_WAIT;
      mf_idx_q <= '0;
    end else if (init_i) begin
      st_q     <= ST_WAIT;
      mf_idx_q <= '0;
    end else begin
      if (adv && st_q == ST_WAIT) st_q <= ST_ILAS;
      if (adv && mf_end && st_q != ST_DATA) begin
        if (mf_idx_q == LAST_MF) st_q <= ST_DATA;
        mf_idx_q <= mf_idx_q + 1'b1;
      end
    end
  end

  // last octet of the latest data frame, source for replacement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                last_q <= '0;
    else if (init_i)            last_q <= '0;
    else if (in_data && frm_end) last_q <= out_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      ctrl_o  <= 1'b0;
      sof_o   <= 1'b0;
    end else begin
      valid_o <= adv;
      data_o  <= out_d;
      ctrl_o  <= ctrl_i && !repl;
      sof_o   <= adv && oct == '0;
    end
  end

  a_r2_lock_sof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_WAIT && valid_i && !is_k && !init_i |=> valid_o && sof_o);
  a_r2_quiet_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_WAIT && !(valid_i && !is_k) |=> !valid_o);
  a_r6_no_repl_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(st_q == ST_DATA) |-> !(ctrl_o && (data_o == CH_F || data_o == CH_A)));
  a_r11_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !valid_o && !cfg_err_o && !frame_alarm_o && !mf_alarm_o);
endmodule

// File: tb/fa_ilas_rx_tb.sv
module fa_ilas_rx_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       init_i = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       ctrl_i = 1'b0;
  logic [4:0] frm_octets_i = 5'd2;
  logic [5:0] mf_frames_i = 6'd4;
  logic [4:0] lane_id_i = 5'd3;
  logic [7:0] cfg_misc_i = 8'h5A;
  logic       valid_o, ctrl_o, sof_o, cfg_err_o, frame_alarm_o, mf_alarm_o;
  logic [7:0] data_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic ov, oc, os;
  logic [7:0] od;

  always #4 clk_i = ~clk_i;

  fa_ilas_rx dut_i (
    .clk_i, .rst_ni, .init_i, .valid_i, .data_i, .ctrl_i,
    .frm_octets_i, .mf_frames_i, .lane_id_i, .cfg_misc_i,
    .valid_o, .data_o, .ctrl_o, .sof_o, .cfg_err_o, .frame_alarm_o, .mf_alarm_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic c);
    @(negedge clk_i);
    data_i = d; ctrl_i = c; valid_i = 1'b1;
    @(posedge clk_i);
    #2;
    ov = valid_o; od = data_o; oc = ctrl_o; os = sof_o;
  endtask

  task automatic pulse_init();
    @(negedge clk_i);
    valid_i = 1'b0; init_i = 1'b1;
    @(posedge clk_i);
    #2;
    chk(!valid_o && !cfg_err_o && !frame_alarm_o && !mf_alarm_o, "R11 init clear",
        {valid_o, cfg_err_o, frame_alarm_o, mf_alarm_o}, 0);
    @(negedge clk_i);
    init_i = 1'b0;
  endtask

  // commas then four multiframes (F=2, K=4)
  task automatic ilas(input logic [7:0] c0, input logic [7:0] c1,
                      input logic [7:0] c2, input logic [7:0] c3);
    for (int i = 0; i < 3; i++) begin
      send(8'hBC, 1'b1);
      chk(!ov, "R2 comma silent", ov, 0);
    end
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 8; p++) begin
        logic [7:0] d;
        logic c;
        c = 1'b0;
        d = 8'(8'h40 + p);
        if (p == 7) begin d = 8'h7C; c = 1'b1; end
        if (m == 1) begin
          case (p)
            0: begin d = 8'h1C; c = 1'b1; end
            1: begin d = 8'h9C; c = 1'b1; end
            2: d = c0;
            3: d = c1;
            4: d = c2;
            5: d = c3;
            default: ;
          endcase
        end
        send(d, c);
        if (m == 0 && p == 0) chk(ov && os, "R2 lock sof", {ov, os}, 3);
        else chk(ov && os == (p % 2 == 0), "R3 sof spacing", {ov, os}, {1'b1, p % 2 == 0});
      end
    end
  endtask

  task automatic t_reset();
    chk(!valid_o && !cfg_err_o && !frame_alarm_o && !mf_alarm_o, "R1 reset state",
        {valid_o, cfg_err_o, frame_alarm_o, mf_alarm_o}, 0);
  endtask

  task automatic t_good_cfg();
    ilas(8'h03, 8'h01, 8'h03, 8'h5A);
    chk(!cfg_err_o, "R5 matching cfg", cfg_err_o, 0);
  endtask

  task automatic t_replace();
    send(8'h10, 1'b0); chk(os && od == 8'h10, "R6 data start", od, 8'h10);
    send(8'h11, 1'b0);
    send(8'h12, 1'b0);
    send(8'hFC, 1'b1); chk(od == 8'h11 && !oc, "R6 F restored", {oc, od}, 8'h11);
    send(8'h14, 1'b0);
    send(8'h15, 1'b0);
    send(8'h16, 1'b0);
    send(8'h7C, 1'b1); chk(od == 8'h15 && !oc, "R7 A restored", {oc, od}, 8'h15);
    chk(!frame_alarm_o && !mf_alarm_o, "R8 no alarm on good", {frame_alarm_o, mf_alarm_o}, 0);
  endtask

  task automatic t_frame_alarm();
    send(8'hFC, 1'b1); chk(!frame_alarm_o, "R8 single miss", frame_alarm_o, 0);
    send(8'hFC, 1'b1);
    send(8'hFC, 1'b1); chk(!frame_alarm_o, "R9 pending cleared", frame_alarm_o, 0);
    send(8'h23, 1'b0);
    send(8'hFC, 1'b1); chk(frame_alarm_o, "R8 two misses", frame_alarm_o, 1);
    send(8'h25, 1'b0);
    send(8'h26, 1'b0); chk(os, "R12 phase kept", os, 1);
    send(8'h27, 1'b0); chk(!os, "R12 phase kept odd", os, 0);
  endtask

  task automatic t_mf_alarm();
    send(8'h30, 1'b0);
    send(8'h7C, 1'b1);
    for (int p = 2; p < 7; p++) send(8'(8'h30 + p), 1'b0);
    send(8'h7C, 1'b1); chk(!mf_alarm_o, "R10 pending cleared", mf_alarm_o, 0);
    send(8'h50, 1'b0);
    send(8'h51, 1'b0);
    send(8'h52, 1'b0);
    send(8'h7C, 1'b1); chk(!mf_alarm_o, "R10 single miss", mf_alarm_o, 0);
    send(8'h54, 1'b0);
    send(8'h7C, 1'b1); chk(mf_alarm_o, "R10 two misses", mf_alarm_o, 1);
    send(8'h56, 1'b0); chk(os, "R12 phase after A alarm", os, 1);
    chk(frame_alarm_o, "R8 alarm sticky", frame_alarm_o, 1);
  endtask

  task automatic t_bad_cfg(input logic [7:0] c0, input logic [7:0] c2, input string tag);
    pulse_init();
    ilas(c0, 8'h01, c2, 8'h5A);
    chk(cfg_err_o, tag, cfg_err_o, 1);
    send(8'h60, 1'b0);
    send(8'h61, 1'b0);
    chk(cfg_err_o, "R4 mismatch sticky", cfg_err_o, 1);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_good_cfg();
    t_replace();
    t_frame_alarm();
    t_mf_alarm();
    t_bad_cfg(8'h07, 8'h03, "R4 lane id mismatch");
    t_bad_cfg(8'h03, 8'h02, "R4 mf length mismatch");
    pulse_init();
    send(8'hBC, 1'b1); chk(!ov, "R11 waiting after init", ov, 0);
    @(negedge clk_i);
    valid_i = 1'b0;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule